// File: doc/BRIEF.md
# PC-Relative Literal Load Unit

This block carries out a load of one 32-bit word from an address formed relative to the program counter. It understands three instruction forms: a fixed-width 32-bit form, and two forms from a compact instruction set, one 16-bit and one 32-bit. An issue stage presents the instruction word together with an encoding-mode selector, the current PC value, the outcome of the condition check and the conditional-block status. The unit rounds the PC down to a word boundary and adds or subtracts a zero-extended immediate. It then makes one read request on a valid/ready memory port.

When the response returns, the data leaves on one of two one-cycle strobes. It goes either to the register file write port, or to a PC-load port when the destination index is 15. Forms that cannot be executed safely finish in one cycle with an unpredictable flag and touch neither memory nor registers. Words that do not match the selected form, and instructions whose condition check failed, finish in one cycle with no side effect. Only one instruction is in flight at a time.

Top module: `lit_load_unit`

## Requirements
- R1: After reset the unit is idle: `insn_ready` is 1, and `busy`, `done`, `unpred`, `mem_req_valid`, `rf_wr_en` and `pc_wr_en` are 0.
- R2: The access address is the PC with bits [1:0] cleared, plus or minus the immediate, modulo 2^XLEN. In the fixed form (`insn_mode`=0) and the compact 32-bit form (`insn_mode`=2), the immediate is bits [11:0] zero-extended. Bit 23 selects add (1) or subtract (0), and bits [15:12] give the destination index.
- R3: The compact 16-bit form (`insn_mode`=1) is recognised by bits [15:11] = 01001. It always adds. Its immediate is bits [7:0] shifted left by two, and its destination index is bits [10:8].
- R4: A fixed form is recognised only when all of the following hold: bits [31:28] ≠ 1111, [27:25] = 010, bit 22 = 0, bit 20 = 1 and [19:16] = 1111. In addition, P (bit 24) = 0 together with W (bit 21) = 1 is a different instruction. A compact 32-bit form is recognised when [31:24] = 0xF8, [22:20] = 101 and [19:16] = 1111. Mode 3 matches nothing. An unrecognised word finishes with `done` for one cycle and no request, no write and no flag.
- R5: A recognised fixed form with P = 0 (W = 0) or with W = 1 (P = 1) asks for writeback. It raises `unpred` with `done` for one cycle, with no memory request and no write.
- R6: An executed load makes exactly one memory request, and `mem_req_addr` stays stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R7: When the destination index is not 15, the returned data appears for one cycle on `rf_wr_en` with `rf_wr_idx` and `rf_wr_data`. When it is 15, the data appears on `pc_wr_en` with `pc_wr_data`. An instruction never asserts both strobes.
- R8: A destination of 15 with an access address whose bits [1:0] ≠ 00 raises `unpred`, with no request and no write.
- R9: In the compact 32-bit form, a destination of 15 raises `unpred` when `it_active` is 1 and `it_last` is 0. When `it_last` is 1, or outside a conditional block, the instruction loads into the PC.
- R10: When `cond_pass` is 0, the instruction finishes with `done` for one cycle and makes no request, no write and raises no flag.
- R11: `busy` is high from acceptance through the writeback cycle, and `insn_ready` is its inverse. An instruction word held valid while busy starts no second request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction presented |
| insn_ready | output | 1 | Unit idle, instruction accepted this cycle |
| insn_word | input | 32 | Instruction bits (16-bit form in [15:0]) |
| insn_mode | input | 2 | 0 fixed 32-bit, 1 compact 16-bit, 2 compact 32-bit |
| pc_value | input | XLEN | PC value used as base |
| cond_pass | input | 1 | Condition check passed |
| it_active | input | 1 | Instruction lies inside a conditional block |
| it_last | input | 1 | Instruction is the last one of that block |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| unpred | output | 1 | Completion was an unpredictable form |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | XLEN | Word read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | XLEN | Read data |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 4 | Register index |
| rf_wr_data | output | XLEN | Register write value |
| pc_wr_en | output | 1 | PC load strobe |
| pc_wr_data | output | XLEN | PC load target |

## Verification
The bench builds the unit with the default XLEN of 32. At that width, subtracting the largest 12-bit offset from a PC near zero wraps around the top of the address space, and both full-range immediates and maximal compact offsets can be checked exactly. Ready delays of zero and several cycles exercise address holding, and an instruction left valid throughout a load shows that no second request starts.

// File: rtl/lit_load_pkg.sv
package lit_load_pkg;

    localparam int INSN_W = 32;
    localparam int IMM_W  = 12;
    localparam int RT_W   = 4;

    localparam logic [1:0]      MODE_FIXED32 = 2'd0;
    localparam logic [1:0]      MODE_CMP16   = 2'd1;
    localparam logic [1:0]      MODE_CMP32   = 2'd2;
    localparam logic [RT_W-1:0] PC_INDEX     = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_WB   = 3'd3,
        ST_FIN  = 3'd4
    } ld_state_e;

    typedef struct packed {
        logic             hit;
        logic             bad;
        logic             add;
        logic [RT_W-1:0]  rt;
        logic [IMM_W-1:0] imm;
    } dec_t;

endpackage

// File: rtl/lit_decoder.sv
module lit_decoder
    import lit_load_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [1:0]        mode,
    input  logic              it_active,
    input  logic              it_last,
    output dec_t              dec
);

    logic p_bit;
    logic w_bit;
    logic fixed_shape;
    logic cmp32_shape;

    assign p_bit = insn[24];
    assign w_bit = insn[21];

    assign fixed_shape = (insn[31:28] != 4'hF) && (insn[27:25] == 3'b010) &&
                         !insn[22] && insn[20] && (insn[19:16] == 4'hF);
    assign cmp32_shape = (insn[31:24] == 8'hF8) && (insn[22:20] == 3'b101) &&
                         (insn[19:16] == 4'hF);

    always_comb begin
        dec = '0;
        case (mode)
            MODE_FIXED32: begin
                dec.hit = fixed_shape && !(!p_bit && w_bit);
                dec.rt  = insn[15:12];
                dec.imm = insn[11:0];
                dec.add = insn[23];
                dec.bad = !p_bit || w_bit;
            end
            MODE_CMP16: begin
                dec.hit = (insn[15:11] == 5'b01001);
                dec.rt  = {1'b0, insn[10:8]};
                dec.imm = {2'b00, insn[7:0], 2'b00};
                dec.add = 1'b1;
                dec.bad = 1'b0;
            end
            MODE_CMP32: begin
                dec.hit = cmp32_shape;
                dec.rt  = insn[15:12];
                dec.imm = insn[11:0];
                dec.add = insn[23];
                dec.bad = (insn[15:12] == PC_INDEX) && it_active && !it_last;
            end
            default: dec = '0;
        endcase
    end

endmodule

// File: rtl/lit_addr_gen.sv
module lit_addr_gen
    import lit_load_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic             add,
    output logic [XLEN-1:0]  addr
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] ext;

    assign base = {pc[XLEN-1:2], 2'b00};
    assign ext  = {{(XLEN-IMM_W){1'b0}}, imm};

    always_comb begin
        if (add) addr = base + ext;
        else     addr = base - ext;
    end

endmodule

// File: rtl/lit_load_unit.sv
module lit_load_unit
    import lit_load_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    output logic              insn_ready,
    input  logic [31:0]       insn_word,
    input  logic [1:0]        insn_mode,
    input  logic [XLEN-1:0]   pc_value,
    input  logic              cond_pass,
    input  logic              it_active,
    input  logic              it_last,
    output logic              busy,
    output logic              done,
    output logic              unpred,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              rf_wr_en,
    output logic [3:0]        rf_wr_idx,
    output logic [XLEN-1:0]   rf_wr_data,
    output logic              pc_wr_en,
    output logic [XLEN-1:0]   pc_wr_data
);

    typedef struct packed {
        ld_state_e       st;
        logic [XLEN-1:0] addr;
        logic [RT_W-1:0] rt;
        logic [XLEN-1:0] data;
        logic            flag;
    } ctx_t;

    ctx_t            ctx_d;
    ctx_t            ctx_q;
    dec_t            dec;
    logic [XLEN-1:0] ld_addr;
    logic            pc_misalign;

    lit_decoder u_dec (
        .insn      (insn_word),
        .mode      (insn_mode),
        .it_active (it_active),
        .it_last   (it_last),
        .dec       (dec)
    );

    lit_addr_gen #(.XLEN(XLEN)) u_agen (
        .pc   (pc_value),
        .imm  (dec.imm),
        .add  (dec.add),
        .addr (ld_addr)
    );

    assign pc_misalign = (dec.rt == PC_INDEX) && (ld_addr[1:0] != 2'b00);

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (insn_valid) begin
                    ctx_d.rt   = dec.rt;
                    ctx_d.addr = ld_addr;
                    ctx_d.flag = 1'b0;
                    if (!cond_pass || !dec.hit) begin
                        ctx_d.st = ST_FIN;
                    end else if (dec.bad || pc_misalign) begin
                        ctx_d.flag = 1'b1;
                        ctx_d.st   = ST_FIN;
                    end else begin
                        ctx_d.st = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    ctx_d.data = mem_rsp_data;
                    ctx_d.st   = ST_WB;
                end
            end
            ST_WB:   ctx_d.st = ST_IDLE;
            ST_FIN:  ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign insn_ready    = (ctx_q.st == ST_IDLE);
    assign busy          = !insn_ready;
    assign mem_req_valid = (ctx_q.st == ST_REQ);
    assign mem_req_addr  = ctx_q.addr;
    assign done          = (ctx_q.st == ST_WB) || (ctx_q.st == ST_FIN);
    assign unpred        = (ctx_q.st == ST_FIN) && ctx_q.flag;
    assign rf_wr_en      = (ctx_q.st == ST_WB) && (ctx_q.rt != PC_INDEX);
    assign rf_wr_idx     = ctx_q.rt;
    assign rf_wr_data    = ctx_q.data;
    assign pc_wr_en      = (ctx_q.st == ST_WB) && (ctx_q.rt == PC_INDEX);
    assign pc_wr_data    = ctx_q.data;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && pc_wr_en));

    // R7
    rf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    // R8
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && (rf_wr_idx == PC_INDEX)) |-> (mem_req_addr[1:0] == 2'b00));

    // R5
    unpred_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unpred |-> (!mem_req_valid && !rf_wr_en && !pc_wr_en && done));

    // R11
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done) |-> (busy && !insn_ready));

endmodule

// File: tb/lit_load_unit_bench.sv
module lit_load_unit_bench;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            insn_valid = 1'b0;
    logic            insn_ready;
    logic [31:0]     insn_word = '0;
    logic [1:0]      insn_mode = '0;
    logic [XLEN-1:0] pc_value = '0;
    logic            cond_pass = 1'b0;
    logic            it_active = 1'b0;
    logic            it_last = 1'b0;
    logic            busy, done, unpred;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [XLEN-1:0] mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [XLEN-1:0] mem_rsp_data = '0;
    logic            rf_wr_en;
    logic [3:0]      rf_wr_idx;
    logic [XLEN-1:0] rf_wr_data;
    logic            pc_wr_en;
    logic [XLEN-1:0] pc_wr_data;

    int n_checks = 0;
    int n_fail   = 0;

    int              n_req, n_unstable, n_wr, n_pc, n_unp, n_busy_bad, n_done;
    logic [XLEN-1:0] req_addr, wr_data, pc_data;
    logic [3:0]      wr_idx;
    bit              finished;

    always #2 clk = ~clk;

    lit_load_unit #(.XLEN(XLEN)) u_lit_load_unit (
        .clk (clk), .rst_n (rst_n),
        .insn_valid (insn_valid), .insn_ready (insn_ready),
        .insn_word (insn_word), .insn_mode (insn_mode), .pc_value (pc_value),
        .cond_pass (cond_pass), .it_active (it_active), .it_last (it_last),
        .busy (busy), .done (done), .unpred (unpred),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .rf_wr_en (rf_wr_en), .rf_wr_idx (rf_wr_idx), .rf_wr_data (rf_wr_data),
        .pc_wr_en (pc_wr_en), .pc_wr_data (pc_wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_fixed(input logic [3:0] cnd, input bit p, input bit u,
                                             input bit w, input logic [3:0] rt, input logic [11:0] imm);
        return {cnd, 3'b010, p, u, 1'b0, w, 1'b1, 4'hF, rt, imm};
    endfunction

    function automatic logic [31:0] mk_c32(input bit u, input logic [3:0] rt, input logic [11:0] imm);
        return {8'hF8, u, 3'b101, 4'hF, rt, imm};
    endfunction

    function automatic logic [31:0] mk_c16(input logic [2:0] rt, input logic [7:0] imm8);
        return {16'h0000, 5'b01001, rt, imm8};
    endfunction

    task automatic exec(input logic [31:0] w, input logic [1:0] m, input logic [31:0] pc,
                        input bit cp, input bit ita, input bit itl, input int rdly,
                        input logic [31:0] data, input bit hold);
        int wc;
        bit hs;
        bit prev_v;
        n_req = 0; n_unstable = 0; n_wr = 0; n_pc = 0; n_unp = 0; n_busy_bad = 0; n_done = 0;
        req_addr = '0; wr_data = '0; pc_data = '0; wr_idx = '0; finished = 0;
        wc = 0; hs = 0; prev_v = 0;
        @(negedge clk);
        insn_word = w; insn_mode = m; pc_value = pc;
        cond_pass = cp; it_active = ita; it_last = itl; insn_valid = 1'b1;
        for (int cyc = 0; cyc < 60 && !finished; cyc++) begin
            @(negedge clk);
            if (!hold) insn_valid = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (busy == insn_ready) n_busy_bad++;
            if (hs) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = data;
                hs = 0;
            end
            if (mem_req_valid) begin
                if (!prev_v) begin
                    n_req++;
                    req_addr = mem_req_addr;
                    wc = 0;
                end else if (mem_req_addr != req_addr) begin
                    n_unstable++;
                end
                if (wc == rdly) begin
                    mem_req_ready = 1'b1;
                    hs = 1;
                end
                wc++;
            end
            if (rf_wr_en) begin n_wr++; wr_idx = rf_wr_idx; wr_data = rf_wr_data; end
            if (pc_wr_en) begin n_pc++; pc_data = pc_wr_data; end
            if (unpred) n_unp++;
            if (done) begin
                n_done++;
                finished = 1;
                insn_valid = 1'b0;
            end
            prev_v = mem_req_valid;
        end
        @(negedge clk);
        if (rf_wr_en || pc_wr_en || unpred || done || mem_req_valid) n_busy_bad++;
        if (!insn_ready) n_busy_bad++;
        chk(finished, "R11 completion reached", finished, 1);
    endtask

    task automatic expect_load(input string tag, input logic [31:0] addr, input bit to_pc,
                               input logic [3:0] rt, input logic [31:0] data);
        chk(n_req == 1, {tag, " R6 request count"}, n_req, 1);
        chk(req_addr == addr, {tag, " R2 address"}, req_addr, addr);
        chk(n_unstable == 0, {tag, " R6 address held"}, n_unstable, 0);
        chk(n_unp == 0, {tag, " unpred clear"}, n_unp, 0);
        chk(n_busy_bad == 0, {tag, " R11 busy/ready"}, n_busy_bad, 0);
        if (to_pc) begin
            chk(n_pc == 1 && n_wr == 0, {tag, " R7 pc strobe only"}, {n_pc[15:0], n_wr[15:0]}, 32'h0001_0000);
            chk(pc_data == data, {tag, " R7 pc data"}, pc_data, data);
        end else begin
            chk(n_wr == 1 && n_pc == 0, {tag, " R7 reg strobe only"}, {n_wr[15:0], n_pc[15:0]}, 32'h0001_0000);
            chk(wr_idx == rt, {tag, " R7 reg index"}, {28'h0, wr_idx}, {28'h0, rt});
            chk(wr_data == data, {tag, " R7 reg data"}, wr_data, data);
        end
    endtask

    task automatic expect_quiet(input string tag, input bit flag);
        chk(n_req == 0, {tag, " no request"}, n_req, 0);
        chk(n_wr == 0 && n_pc == 0, {tag, " no write"}, n_wr + n_pc, 0);
        chk(n_unp == (flag ? 1 : 0), {tag, " unpred flag"}, n_unp, flag ? 1 : 0);
        chk(n_done == 1, {tag, " done pulse"}, n_done, 1);
        chk(n_busy_bad == 0, {tag, " R11 busy/ready"}, n_busy_bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(insn_ready && !busy && !done && !unpred, "R1 idle handshake", {busy, done, unpred, insn_ready}, 32'h1);
        chk(!mem_req_valid && !rf_wr_en && !pc_wr_en, "R1 no strobes", {mem_req_valid, rf_wr_en, pc_wr_en}, 0);
    endtask

    task automatic t_fixed_add;
        exec(mk_fixed(4'hE, 1, 1, 0, 4'd3, 12'h123), 2'd0, 32'h0000_1006, 1, 0, 0, 0, 32'hDEAD_BEEF, 0);
        expect_load("R2 fixed add", 32'h0000_1127, 0, 4'd3, 32'hDEAD_BEEF);
    endtask

    task automatic t_fixed_sub_pc;
        exec(mk_fixed(4'h0, 1, 0, 0, 4'd15, 12'h010), 2'd0, 32'h0000_2003, 1, 0, 0, 3, 32'h0000_4001, 0);
        expect_load("R7 fixed sub to pc", 32'h0000_1FF0, 1, 4'd15, 32'h0000_4001);
    endtask

    task automatic t_wrap;
        exec(mk_fixed(4'hE, 1, 0, 0, 4'd2, 12'hFFF), 2'd0, 32'h0000_0008, 1, 0, 0, 1, 32'h1234_5678, 0);
        expect_load("R2 wrap below zero", 32'hFFFF_F009, 0, 4'd2, 32'h1234_5678);
    endtask

    task automatic t_cmp16;
        exec(mk_c16(3'd5, 8'hFF), 2'd1, 32'h0000_3002, 1, 0, 0, 0, 32'hA5A5_0F0F, 0);
        expect_load("R3 compact16 max", 32'h0000_33FC, 0, 4'd5, 32'hA5A5_0F0F);
        exec({16'hFFFF, 5'b01001, 3'd7, 8'h01}, 2'd1, 32'h0000_0100, 1, 0, 0, 2, 32'h0BAD_F00D, 0);
        expect_load("R3 compact16 upper ignored", 32'h0000_0104, 0, 4'd7, 32'h0BAD_F00D);
    endtask

    task automatic t_cmp32;
        exec(mk_c32(0, 4'd12, 12'hFFF), 2'd2, 32'h0001_0000, 1, 0, 0, 0, 32'hCAFE_0001, 0);
        expect_load("R2 compact32 sub", 32'h0000_F001, 0, 4'd12, 32'hCAFE_0001);
    endtask

    task automatic t_it_rules;
        exec(mk_c32(1, 4'd15, 12'h008), 2'd2, 32'h0000_0400, 1, 1, 0, 0, 32'h1111_0000, 0);
        expect_quiet("R9 pc in block not last", 1);
        exec(mk_c32(1, 4'd15, 12'h008), 2'd2, 32'h0000_0400, 1, 1, 1, 0, 32'h2222_0000, 0);
        expect_load("R9 pc last in block", 32'h0000_0408, 1, 4'd15, 32'h2222_0000);
        exec(mk_c32(1, 4'd4, 12'h008), 2'd2, 32'h0000_0400, 1, 1, 0, 0, 32'h3333_0000, 0);
        expect_load("R9 non-pc in block", 32'h0000_0408, 0, 4'd4, 32'h3333_0000);
    endtask

    task automatic t_writeback;
        exec(mk_fixed(4'hE, 1, 1, 1, 4'd1, 12'h004), 2'd0, 32'h0000_0800, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R5 pre-index writeback", 1);
        exec(mk_fixed(4'hE, 0, 1, 0, 4'd1, 12'h004), 2'd0, 32'h0000_0800, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R5 post-index", 1);
    endtask

    task automatic t_nomatch;
        exec(mk_fixed(4'hE, 0, 1, 1, 4'd1, 12'h004), 2'd0, 32'h0000_0800, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R4 P0W1 other insn", 0);
        exec(mk_fixed(4'hF, 1, 1, 0, 4'd1, 12'h004), 2'd0, 32'h0000_0800, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R4 cond 1111", 0);
        exec(mk_fixed(4'hE, 1, 1, 0, 4'd1, 12'h004) & ~32'h0001_0000, 2'd0, 32'h0000_0800, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R4 base not pc", 0);
        exec(mk_c16(3'd1, 8'h01), 2'd3, 32'h0000_0800, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R4 mode 3", 0);
        exec(mk_c32(1, 4'd1, 12'h004), 2'd1, 32'h0000_0800, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R4 wrong mode", 0);
    endtask

    task automatic t_misalign;
        exec(mk_fixed(4'hE, 1, 1, 0, 4'd15, 12'h002), 2'd0, 32'h0000_0500, 1, 0, 0, 0, 32'h0, 0);
        expect_quiet("R8 pc misaligned", 1);
        exec(mk_fixed(4'hE, 1, 1, 0, 4'd6, 12'h002), 2'd0, 32'h0000_0500, 1, 0, 0, 0, 32'h5555_AAAA, 0);
        expect_load("R8 reg misaligned allowed", 32'h0000_0502, 0, 4'd6, 32'h5555_AAAA);
    endtask

    task automatic t_cond_fail;
        exec(mk_fixed(4'hE, 1, 1, 0, 4'd3, 12'h010), 2'd0, 32'h0000_0600, 0, 0, 0, 0, 32'h0, 0);
        expect_quiet("R10 cond fail", 0);
        exec(mk_fixed(4'hE, 1, 1, 1, 4'd3, 12'h010), 2'd0, 32'h0000_0600, 0, 0, 0, 0, 32'h0, 0);
        expect_quiet("R10 cond fail beats unpred", 0);
    endtask

    task automatic t_hold_busy;
        exec(mk_c16(3'd2, 8'h10), 2'd1, 32'h0000_0700, 1, 0, 0, 4, 32'h7777_8888, 1);
        expect_load("R11 held insn", 32'h0000_0740, 0, 4'd2, 32'h7777_8888);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed_add();
        t_fixed_sub_pc();
        t_wrap();
        t_cmp16();
        t_cmp32();
        t_it_rules();
        t_writeback();
        t_nomatch();
        t_misalign();
        t_cond_fail();
        t_hold_busy();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule